// File: doc/BRIEF.md
# Evicted-Address Reuse Predictor

This block sits beside a last-level cache controller. It tells the cache whether a block that has just missed is likely to be used again. Every block address that the cache evicts is recorded in a tag-free Bloom filter bit array. When the cache misses, it sends the missed block address as a query. The block answers one cycle later with a reuse prediction. High reuse means the address was evicted recently and has come back. Low reuse means it was not. The cache uses this prediction to choose where the incoming line goes in its insertion policy.

The block counts the evictions it records. When that count reaches a programmable limit, it wipes the whole array in one cycle. As a result, only part of a thrashing working set is ever predicted as high reuse. A typical limit equals the number of blocks the cache holds, for example 1024. The block keeps no per-block reuse counters and no tags. Its only state is the bit array and the insertion counter.

Top module: `evict_reuse_predictor`

## Requirements
- R1: An eviction (`evict_valid_i`=1) inserts its address. A miss query for that same address in any later cycle, before the next clear, yields `pred_reuse_o`=1.
- R2: `pred_valid_o` is 1 in exactly the cycle after a cycle with `miss_valid_i`=1, and 0 after a cycle with `miss_valid_i`=0.
- R3: A query hits, giving `pred_reuse_o`=1, when both bits selected by the two hashes of its address are set.
- R4: A query for which either selected bit is clear gives `pred_reuse_o`=0. After reset or a clear, this applies to every address.
- R5: The array holds 1024 bits with 10-bit indices. The block address is zero-extended to a whole number of 10-bit chunks, with chunk k at bits [10k+9:10k]. Index 0 is the XOR of all chunks. Index 1 is the XOR of all chunks after chunk k is rotated left by (k+1) mod 10.
- R6: An insertion counter starts at 0. At the edge that ends a cycle in which the counter is at least `clear_limit_i`, with `clear_limit_i` not 0, all bits and the counter are cleared. A limit of 0 never clears.
- R7: When a query and an insertion occur in the same cycle, the query sees the array as it was before that insertion.
- R8: When an insertion coincides with a clear, the clear applies first. The new address's bits are then set, and the counter becomes 1.
- R9: The active-low asynchronous reset clears all filter bits, the counter, `pred_valid_o` and `pred_reuse_o`.
- R10: `pred_reuse_o` is 0 whenever `pred_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | An eviction is reported this cycle |
| evict_addr_i | input | ADDR_W (26) | Block address of the evicted line |
| miss_valid_i | input | 1 | A miss query is made this cycle |
| miss_addr_i | input | ADDR_W (26) | Block address of the missed line |
| clear_limit_i | input | CNT_W (11) | Number of insertions that triggers a clear; 0 disables clearing |
| pred_valid_o | output | 1 | The prediction for last cycle's query is valid |
| pred_reuse_o | output | 1 | 1 = high reuse, 0 = low reuse |

## Verification
The bench aims first at the same-cycle orderings. A query made together with an insertion of the same address must still report low reuse. A design that read the array after its update would report high reuse there instead. The clearing cycle is also probed. A query made in that cycle must still see the old contents, and an insertion made in that cycle must survive the wipe. A design that cleared one cycle late, or that wiped after setting, would lose that address or keep stale ones. The bench also crafts addresses whose first hash collides with a stored address while their second hash does not, so a design that tested only one bit would report false reuse. A zero limit and a mid-run reset complete the coverage of the counter.

// File: rtl/evp_pkg.sv
package evp_pkg;
  typedef enum logic {HASH_PLAIN = 1'b0, HASH_ROT = 1'b1} hash_kind_e;
  localparam int DEF_ADDR_W      = 26;
  localparam int DEF_FILTER_BITS = 1024;
endpackage

// File: rtl/evp_hash.sv
module evp_hash import evp_pkg::*; #(
  parameter int         ADDR_W = DEF_ADDR_W,
  parameter int         IDX_W  = 10,
  parameter hash_kind_e KIND   = HASH_PLAIN
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  function automatic logic [IDX_W-1:0] rotl(input logic [IDX_W-1:0] c, input int r);
    logic [IDX_W-1:0] o;
    for (int b = 0; b < IDX_W; b++) o[(b + r) % IDX_W] = c[b];
    return o;
  endfunction

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(addr_i);

  generate
    if (KIND == HASH_ROT) begin : g_rot
      always_comb begin
        idx_o = '0;
        for (int k = 0; k < NCHUNK; k++)
          idx_o = idx_o ^ rotl(padded[k*IDX_W +: IDX_W], (k + 1) % IDX_W);
      end
    end else begin : g_plain
      always_comb begin
        idx_o = '0;
        for (int k = 0; k < NCHUNK; k++)
          idx_o = idx_o ^ padded[k*IDX_W +: IDX_W];
      end
    end
  endgenerate
endmodule

// File: rtl/evp_bit_array.sv
module evp_bit_array #(
  parameter int NBITS = 1024,
  parameter int IDX_W = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx0_i,
  input  logic [IDX_W-1:0] set_idx1_i,
  input  logic [IDX_W-1:0] tst_idx0_i,
  input  logic [IDX_W-1:0] tst_idx1_i,
  output logic             tst_hit_o
);
  logic [NBITS-1:0] bits_q, bits_d;

  // clear takes effect before the set of the same cycle
  always_comb begin
    bits_d = clr_i ? '0 : bits_q;
    if (set_i) begin
      bits_d[set_idx0_i] = 1'b1;
      bits_d[set_idx1_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  // test reads the pre-update state
  assign tst_hit_o = bits_q[tst_idx0_i] & bits_q[tst_idx1_i];
endmodule

// File: rtl/evp_clear_ctrl.sv
module evp_clear_ctrl #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             clr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign clr_o = (limit_i != '0) && (cnt_q >= limit_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_o) cnt_q <= {{(CNT_W-1){1'b0}}, ins_i};
    else if (ins_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evict_reuse_predictor.sv
module evict_reuse_predictor import evp_pkg::*; #(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int FILTER_BITS = DEF_FILTER_BITS,
  parameter int CNT_W       = $clog2(FILTER_BITS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [CNT_W-1:0]  clear_limit_i,
  output logic              pred_valid_o,
  output logic              pred_reuse_o
);
  localparam int IDX_W = $clog2(FILTER_BITS);

  logic [IDX_W-1:0] ev_idx [2];
  logic [IDX_W-1:0] mq_idx [2];
  logic             clr_now;
  logic [CNT_W-1:0] ins_cnt;
  logic             hit;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_hash
      localparam hash_kind_e KIND = hash_kind_e'(g);
      evp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KIND(KIND)) u_ev_hash (
        .addr_i(evict_addr_i), .idx_o(ev_idx[g]));
      evp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KIND(KIND)) u_mq_hash (
        .addr_i(miss_addr_i), .idx_o(mq_idx[g]));
    end
  endgenerate

  evp_clear_ctrl #(.CNT_W(CNT_W)) u_clr (
    .clk_i, .rst_ni,
    .ins_i  (evict_valid_i),
    .limit_i(clear_limit_i),
    .clr_o  (clr_now),
    .cnt_o  (ins_cnt)
  );

  evp_bit_array #(.NBITS(FILTER_BITS), .IDX_W(IDX_W)) u_arr (
    .clk_i, .rst_ni,
    .clr_i     (clr_now),
    .set_i     (evict_valid_i),
    .set_idx0_i(ev_idx[0]),
    .set_idx1_i(ev_idx[1]),
    .tst_idx0_i(mq_idx[0]),
    .tst_idx1_i(mq_idx[1]),
    .tst_hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_reuse_o <= 1'b0;
    end else begin
      pred_valid_o <= miss_valid_i;
      pred_reuse_o <= miss_valid_i & hit;
    end
  end
endmodule

// File: rtl/evp_checker.sv
module evp_checker #(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_valid_i,
  input logic [ADDR_W-1:0] evict_addr_i,
  input logic              miss_valid_i,
  input logic [ADDR_W-1:0] miss_addr_i,
  input logic              pred_valid_o,
  input logic              pred_reuse_o,
  input logic              clr_now_i,
  input logic [CNT_W-1:0]  ins_cnt_i
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> pred_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> !pred_valid_o);
  assert_reuse_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> !pred_reuse_o);
  assert_insert_visible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evict_valid_i) && miss_valid_i && miss_addr_i == $past(evict_addr_i)) |=> pred_reuse_o);
  assert_clear_counter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_now_i |=> ins_cnt_i == {{(CNT_W-1){1'b0}}, $past(evict_valid_i)});
endmodule

bind evict_reuse_predictor evp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_evp_checker (
  .clk_i, .rst_ni, .evict_valid_i, .evict_addr_i, .miss_valid_i, .miss_addr_i,
  .pred_valid_o, .pred_reuse_o, .clr_now_i(clr_now), .ins_cnt_i(ins_cnt));

// File: tb/evict_reuse_predictor_test.sv
module evict_reuse_predictor_test;
  localparam int AW = 26;
  localparam int CW = 11;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ev = 0, mq = 0;
  logic [AW-1:0] ea = '0, ma = '0;
  logic [CW-1:0] lim = 11'd1024;
  logic          pv, pr;

  int errors = 0, checks = 0;
  bit mdl [1024];
  int mdl_cnt = 0;

  always #2 clk = ~clk;

  evict_reuse_predictor uut (
    .clk_i(clk), .rst_ni(rst_n), .evict_valid_i(ev), .evict_addr_i(ea),
    .miss_valid_i(mq), .miss_addr_i(ma), .clear_limit_i(lim),
    .pred_valid_o(pv), .pred_reuse_o(pr));

  function automatic int hsh(input logic [AW-1:0] a, input bit rot);
    logic [9:0] acc = '0;
    for (int k = 0; k < 3; k++) begin
      logic [9:0] ch, rc;
      for (int b = 0; b < 10; b++) ch[b] = (k*10 + b < AW) ? a[k*10 + b] : 1'b0;
      for (int b = 0; b < 10; b++) rc[(b + (rot ? k + 1 : 0)) % 10] = ch[b];
      acc = acc ^ rc;
    end
    return int'(acc);
  endfunction

  function automatic bit in_model(input logic [AW-1:0] a);
    return mdl[hsh(a, 0)] && mdl[hsh(a, 1)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic step(input bit e, input logic [AW-1:0] eaddr, input bit q,
                      input logic [AW-1:0] qaddr, input string req);
    bit exp;
    ev = e; ea = eaddr; mq = q; ma = qaddr;
    exp = q && in_model(qaddr);
    if (lim != 0 && mdl_cnt >= int'(lim)) begin
      for (int i = 0; i < 1024; i++) mdl[i] = 0;
      mdl_cnt = 0;
    end
    if (e) begin
      mdl[hsh(eaddr, 0)] = 1; mdl[hsh(eaddr, 1)] = 1; mdl_cnt++;
    end
    @(negedge clk);
    chk(pv == q, "R2 valid", int'(pv), int'(q));
    chk(pr == exp, req, int'(pr), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 0; ev = 0; mq = 0;
    for (int i = 0; i < 1024; i++) mdl[i] = 0;
    mdl_cnt = 0;
    @(negedge clk);
    chk(pv == 0 && pr == 0, "R9 outputs in reset", int'({pv, pr}), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, "R10 idle");
  endtask

  task automatic t_reset();
    do_reset();
    step(0, '0, 1, 26'h0000000, "R4 R9 empty after reset");
    step(0, '0, 1, 26'h3ffffff, "R4 R9 empty after reset");
    step(0, '0, 1, 26'h1234567, "R4 R9 empty after reset");
    idle();
  endtask

  task automatic t_insert_query();
    logic [AW-1:0] a [4] = '{26'h0000040, 26'h1abcdef, 26'h2000001, 26'h0f0f0f0};
    for (int i = 0; i < 4; i++) step(1, a[i], 0, '0, "R1 insert");
    for (int i = 0; i < 4; i++) begin
      step(0, '0, 1, a[i], "R1 R3 evicted address predicted reuse");
      chk(pr == 1, "R1 R3 must hit", int'(pr), 1);
    end
    idle();
  endtask

  task automatic t_absent();
    logic [AW-1:0] base = 26'h1abcdef;
    logic [AW-1:0] alias0;
    // same chunk-XOR (index 0), different rotated fold (index 1)
    alias0 = base ^ {6'h0, 10'h155, 10'h155};
    chk(hsh(alias0, 0) == hsh(base, 0), "R5 bench alias", hsh(alias0, 0), hsh(base, 0));
    step(0, '0, 1, alias0, "R4 R5 only one index matches");
    step(0, '0, 1, 26'h0000041, "R4 absent address");
    step(0, '0, 1, 26'h3333333, "R4 absent address");
    idle();
  endtask

  task automatic t_valid_timing();
    idle(); idle();
    step(0, '0, 1, 26'h0000040, "R2 R3 back-to-back query 1");
    step(0, '0, 1, 26'h0000123, "R2 R4 back-to-back query 2");
    step(0, '0, 0, 26'h0000040, "R10 no query, address ignored");
    chk(pr == 0, "R10 reuse low without valid", int'(pr), 0);
  endtask

  task automatic t_same_cycle();
    logic [AW-1:0] x = 26'h2468ace;
    step(1, x, 1, x, "R7 query sees pre-insert state");
    chk(pr == 0, "R7 must miss", int'(pr), 0);
    step(0, '0, 1, x, "R7 R1 visible next cycle");
    chk(pr == 1, "R7 must hit after", int'(pr), 1);
    idle();
  endtask

  task automatic t_clear();
    lim = 11'd3;
    do_reset();
    step(1, 26'h0000011, 0, '0, "R6 ins1");
    step(1, 26'h0000022, 0, '0, "R6 ins2");
    step(1, 26'h0000033, 0, '0, "R6 ins3");
    step(0, '0, 1, 26'h0000011, "R6 query in clear cycle sees old state");
    chk(pr == 1, "R6 hit before wipe", int'(pr), 1);
    step(0, '0, 1, 26'h0000011, "R6 wiped after limit");
    chk(pr == 0, "R6 miss after wipe", int'(pr), 0);
    step(0, '0, 1, 26'h0000033, "R6 wiped after limit");
    idle();
  endtask

  task automatic t_clear_insert();
    lim = 11'd2;
    do_reset();
    step(1, 26'h0000101, 0, '0, "R8 ins1");
    step(1, 26'h0000202, 0, '0, "R8 ins2");
    step(1, 26'h0000303, 0, '0, "R8 insert during clear");
    step(0, '0, 1, 26'h0000303, "R8 survives clear");
    chk(pr == 1, "R8 new address kept", int'(pr), 1);
    step(0, '0, 1, 26'h0000101, "R8 old address wiped");
    step(1, 26'h0000404, 0, '0, "R8 count now two");
    step(0, '0, 1, 26'h0000404, "R8 present before next clear");
    step(0, '0, 1, 26'h0000404, "R8 counter restarted at 1, cleared again");
    chk(pr == 0, "R8 second wipe", int'(pr), 0);
    idle();
  endtask

  task automatic t_limit_zero();
    lim = 11'd0;
    do_reset();
    for (int i = 0; i < 20; i++) step(1, AW'(i * 4099 + 7), 0, '0, "R6 fill");
    for (int i = 0; i < 20; i++) step(0, '0, 1, AW'(i * 4099 + 7), "R6 limit 0 never clears");
    chk(pr == 1, "R6 last still present", int'(pr), 1);
    idle();
  endtask

  task automatic t_midrun_reset();
    lim = 11'd1024;
    step(1, 26'h0055aa5, 0, '0, "R9 ins");
    do_reset();
    step(0, '0, 1, 26'h0055aa5, "R9 reset wipes filter");
    chk(pr == 0, "R9 miss after reset", int'(pr), 0);
    idle();
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_insert_query();
        t_absent();
        t_valid_timing();
        t_same_cycle();
        t_clear();
        t_clear_insert();
        t_limit_zero();
        t_midrun_reset();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule